// File: doc/BRIEF.md
# Off-Line Self-Test Sequencer

This block runs a structural self-test on a combinational circuit with N_IN inputs and M_OUT outputs. After a start request it latches its run settings and seeds its two registers. It then applies a chosen number of patterns. For each pattern it holds the stimulus through a programmable number of scan-shift cycles, strobes one capture cycle and folds the sampled response into a signature register. At the end it compares the signature with an expected value and raises a done flag together with a pass verdict.

Two pattern sources are available, and the mode input picks one per run. The first is an exhaustive binary counter that starts at zero. The second is a seeded autonomous LFSR with internal XOR taps at the stages whose feedback-constant bit is 1. A zero seed would lock the LFSR at zero, so it is replaced with a fixed nonzero default. The signature register is a multiple-input shift register built on the same feedback polynomial.

Top module: `bist_ctrl`

## Requirements
- R1: A start request in IDLE or DONE latches the mode, seed, shift length, pattern limit and expected signature. The next cycle is a seed cycle. In the cycle after that the pattern output holds the first pattern: zero in counter mode (mode 0), or the seed in LFSR mode (mode 1). The signature register restarts at zero.
- R2: Each pattern is held stable during a scan phase in which shift_en_o is high for exactly max(L,1) consecutive cycles, where L is the latched shift length.
- R3: Each scan phase is followed by exactly one capture_o cycle and then one compaction cycle, with all outputs low. After that comes either the next scan phase or DONE, once the latched limit of patterns has been compacted. A limit of 0 goes from the seed cycle straight to DONE.
- R4: In counter mode the next pattern is the current pattern plus 1, modulo 2^N_IN, so a run of 2^N_IN patterns applies every input combination once.
- R5: In LFSR mode the next pattern is {p[N-2:0],0} XOR (p[N-1] ? POLY : 0). The default POLY is 8'h1D (taps x^8+x^4+x^3+x^2+1).
- R6: With the default primitive polynomial and a nonzero seed, a run of 255 LFSR patterns applies 255 distinct nonzero patterns.
- R7: A zero seed in LFSR mode is replaced by the default value 1, so the first pattern is 1.
- R8: The response present on response_i during the capture cycle updates the signature in the compaction cycle to step(sig) XOR response, where step is the R5 function on M_OUT bits.
- R9: done_o stays high from the end of the last compaction until a start request is accepted. pass_o is high only while done_o is high, and only when the final signature equals the latched expected signature.
- R10: A start request during the seed, scan, capture or compaction cycles is ignored. The run continues unchanged.
- R11: A synchronous active-high reset returns the block to IDLE with done_o, pass_o, shift_en_o and capture_o low and pattern_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, accepted in IDLE or DONE |
| mode_i | input | 1 | 0 = exhaustive counter, 1 = LFSR |
| seed_i | input | N_IN | LFSR seed |
| shift_len_i | input | SHIFT_W | Scan shift cycles per pattern (0 acts as 1) |
| pat_limit_i | input | CNT_W | Number of patterns in the run |
| exp_sig_i | input | M_OUT | Expected final signature |
| response_i | input | M_OUT | Response from the circuit under test |
| pattern_o | output | N_IN | Stimulus to the circuit under test |
| shift_en_o | output | 1 | Scan shift phase active |
| capture_o | output | 1 | Response capture strobe |
| done_o | output | 1 | Run finished, held until the next start |
| pass_o | output | 1 | Signature matched, valid while done_o is high |

## Verification
A start sampled at clock edge k produces the seed cycle after edge k. The first pattern and shift_en_o appear after edge k+1. capture_o follows max(L,1) cycles later, the compaction cycle one cycle after that, and done_o with its pass verdict after the edge that ends the last compaction. The bench keeps a behavioural model that takes the same edges and compares every output at each falling edge. Each result is therefore checked in exactly the cycle it is due. Targeted checks add to this: the first pattern two edges after start, LFSR uniqueness over a full period, and the pass verdict against a signature computed independently.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEED  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_CAPT  = 3'd3,
        ST_COMP  = 3'd4,
        ST_DONE  = 3'd5
    } bist_state_e;

    typedef enum logic {
        GEN_COUNT = 1'b0,
        GEN_LFSR  = 1'b1
    } gen_mode_e;

    // control strobes from the sequencer to the datapath
    typedef struct packed {
        logic accept;   // start request taken this cycle
        logic load;     // seed cycle: load generator, clear signature
        logic shift;    // scan shift phase
        logic capture;  // sample response
        logic compact;  // fold response, advance generator
    } seq_ctl_t;

    function automatic logic is_quiescent(bist_state_e st);
        return (st == ST_IDLE) || (st == ST_DONE);
    endfunction

endpackage

// File: rtl/bist_seq.sv
module bist_seq
    import bist_pkg::*;
#(
    parameter int SHIFT_W = 4,
    parameter int CNT_W   = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [SHIFT_W-1:0] shift_len,
    input  logic [CNT_W-1:0]   pat_limit,
    output bist_state_e        state,
    output seq_ctl_t           ctl
);
    localparam int PW = CNT_W + 1;

    bist_state_e        st_q;
    logic [SHIFT_W-1:0] shift_cnt_q;
    logic [CNT_W-1:0]   pat_cnt_q;
    logic [SHIFT_W-1:0] shift_last;
    logic [PW-1:0]      pat_next;
    logic               last_shift;
    logic               last_pat;

    assign shift_last = (shift_len == '0) ? '0 : shift_len - 1'b1;
    assign last_shift = (shift_cnt_q == shift_last);
    assign pat_next   = {1'b0, pat_cnt_q} + 1'b1;
    assign last_pat   = (pat_next == {1'b0, pat_limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            shift_cnt_q <= '0;
            pat_cnt_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_DONE: begin
                    if (start_i) st_q <= ST_SEED;
                end
                ST_SEED: begin
                    shift_cnt_q <= '0;
                    pat_cnt_q   <= '0;
                    st_q        <= (pat_limit == '0) ? ST_DONE : ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (last_shift) begin
                        shift_cnt_q <= '0;
                        st_q        <= ST_CAPT;
                    end else begin
                        shift_cnt_q <= shift_cnt_q + 1'b1;
                    end
                end
                ST_CAPT: st_q <= ST_COMP;
                ST_COMP: begin
                    pat_cnt_q <= pat_next[CNT_W-1:0];
                    st_q      <= last_pat ? ST_DONE : ST_SHIFT;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl         = '0;
        ctl.accept  = is_quiescent(st_q) && start_i;
        ctl.load    = (st_q == ST_SEED);
        ctl.shift   = (st_q == ST_SHIFT);
        ctl.capture = (st_q == ST_CAPT);
        ctl.compact = (st_q == ST_COMP);
    end

    assign state = st_q;

endmodule

// File: rtl/bist_tpg.sv
module bist_tpg #(
    parameter int             N    = 8,
    parameter logic [N-1:0]   POLY = 'h1D,
    parameter logic [N-1:0]   DFLT = 'h01
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         advance,
    input  logic         use_lfsr,
    input  logic [N-1:0] seed,
    output logic [N-1:0] pattern
);
    logic [N-1:0] gen_q;
    logic [N-1:0] lfsr_nxt;
    logic [N-1:0] cnt_nxt;
    logic [N-1:0] seed_safe;
    logic         fb;

    assign fb = gen_q[N-1];

    // internal-XOR LFSR: a tap bit of 1 puts an XOR at that stage
    for (genvar i = 0; i < N; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign lfsr_nxt[i] = POLY[i] & fb;
        end else begin : g_rest
            if (POLY[i]) begin : g_tap
                assign lfsr_nxt[i] = gen_q[i-1] ^ fb;
            end else begin : g_wire
                assign lfsr_nxt[i] = gen_q[i-1];
            end
        end
    end

    assign cnt_nxt   = gen_q + 1'b1;
    assign seed_safe = (seed == '0) ? DFLT : seed;

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= '0;
        end else if (load) begin
            gen_q <= use_lfsr ? seed_safe : '0;
        end else if (advance) begin
            gen_q <= use_lfsr ? lfsr_nxt : cnt_nxt;
        end
    end

    assign pattern = gen_q;

endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
    parameter int           M    = 8,
    parameter logic [M-1:0] POLY = 'h1D
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         capture,
    input  logic         compact,
    input  logic [M-1:0] resp,
    output logic [M-1:0] sig
);
    logic [M-1:0] sig_q;
    logic [M-1:0] resp_q;
    logic [M-1:0] shifted;
    logic         fb;

    assign fb = sig_q[M-1];

    for (genvar i = 0; i < M; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign shifted[i] = POLY[i] & fb;
        end else begin : g_rest
            if (POLY[i]) begin : g_tap
                assign shifted[i] = sig_q[i-1] ^ fb;
            end else begin : g_wire
                assign shifted[i] = sig_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else if (capture) begin
            resp_q <= resp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sig_q <= '0;
        end else if (compact) begin
            sig_q <= shifted ^ resp_q;
        end
    end

    assign sig = sig_q;

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
    import bist_pkg::*;
#(
    parameter int                N_IN      = 8,
    parameter int                M_OUT     = 8,
    parameter int                SHIFT_W   = 4,
    parameter int                CNT_W     = 10,
    parameter logic [N_IN-1:0]   TPG_POLY  = 'h1D,
    parameter logic [M_OUT-1:0]  MISR_POLY = 'h1D,
    parameter logic [N_IN-1:0]   SEED_DFLT = 'h01
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               mode_i,
    input  logic [N_IN-1:0]    seed_i,
    input  logic [SHIFT_W-1:0] shift_len_i,
    input  logic [CNT_W-1:0]   pat_limit_i,
    input  logic [M_OUT-1:0]   exp_sig_i,
    input  logic [M_OUT-1:0]   response_i,
    output logic [N_IN-1:0]    pattern_o,
    output logic               shift_en_o,
    output logic               capture_o,
    output logic               done_o,
    output logic               pass_o
);
    typedef struct packed {
        gen_mode_e          mode;
        logic [N_IN-1:0]    seed;
        logic [SHIFT_W-1:0] shift_len;
        logic [CNT_W-1:0]   limit;
        logic [M_OUT-1:0]   exp_sig;
    } run_cfg_t;

    run_cfg_t          cfg_q;
    bist_state_e       state;
    seq_ctl_t          ctl;
    logic [M_OUT-1:0]  sig;
    logic              run_lfsr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (ctl.accept) begin
            cfg_q.mode      <= gen_mode_e'(mode_i);
            cfg_q.seed      <= seed_i;
            cfg_q.shift_len <= shift_len_i;
            cfg_q.limit     <= pat_limit_i;
            cfg_q.exp_sig   <= exp_sig_i;
        end
    end

    assign run_lfsr = (cfg_q.mode == GEN_LFSR);

    bist_seq #(
        .SHIFT_W (SHIFT_W),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .shift_len (cfg_q.shift_len),
        .pat_limit (cfg_q.limit),
        .state     (state),
        .ctl       (ctl)
    );

    bist_tpg #(
        .N    (N_IN),
        .POLY (TPG_POLY),
        .DFLT (SEED_DFLT)
    ) u_tpg (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .advance  (ctl.compact),
        .use_lfsr (run_lfsr),
        .seed     (cfg_q.seed),
        .pattern  (pattern_o)
    );

    bist_misr #(
        .M    (M_OUT),
        .POLY (MISR_POLY)
    ) u_misr (
        .clk     (clk),
        .rst     (rst),
        .clear   (ctl.load),
        .capture (ctl.capture),
        .compact (ctl.compact),
        .resp    (response_i),
        .sig     (sig)
    );

    assign shift_en_o = ctl.shift;
    assign capture_o  = ctl.capture;
    assign done_o     = (state == ST_DONE);
    assign pass_o     = done_o && (sig == cfg_q.exp_sig);

endmodule

// File: rtl/bist_ctrl_chk.sv
module bist_ctrl_chk #(
    parameter int N_IN = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic [N_IN-1:0] pattern_o,
    input logic            shift_en_o,
    input logic            capture_o,
    input logic            done_o,
    input logic            pass_o,
    input logic            run_lfsr
);
    // R2: stimulus held through consecutive scan cycles
    assert_pattern_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (shift_en_o && $past(shift_en_o)) |-> $stable(pattern_o));

    // R3: a capture strobe always directly follows a scan cycle
    assert_capture_after_shift_R3: assert property (@(posedge clk) disable iff (rst)
        capture_o |-> $past(shift_en_o));

    // R3: capture lasts one cycle and is followed by a quiet compaction cycle
    assert_single_capture_R3: assert property (@(posedge clk) disable iff (rst)
        capture_o |=> (!capture_o && !shift_en_o && !done_o));

    // R3: at most one phase output active
    assert_one_phase_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({shift_en_o, capture_o, done_o}));

    // R7: LFSR stimulus is never zero
    assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        (shift_en_o && run_lfsr) |-> (pattern_o != '0));

    // R9: done holds until a start request
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

    // R9: pass only with done
    assert_pass_gated_R9: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> done_o);

    // R10: a start request during scan cannot abort the scan/capture flow
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (shift_en_o && start_i) |=> (shift_en_o || capture_o));

    // R11: reset leaves all phase outputs low
    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (!done_o && !shift_en_o && !capture_o && !pass_o));

endmodule

bind bist_ctrl bist_ctrl_chk #(.N_IN(N_IN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .pattern_o  (pattern_o),
    .shift_en_o (shift_en_o),
    .capture_o  (capture_o),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .run_lfsr   (run_lfsr)
);

// File: tb/bist_ctrl_tb.sv
module bist_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int M = 8;
    localparam int SW = 4;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [N-1:0]  seed_i = '0;
    logic [SW-1:0] shift_len_i = '0;
    logic [CW-1:0] pat_limit_i = '0;
    logic [M-1:0]  exp_sig_i = '0;
    logic [M-1:0]  response_i;
    logic [N-1:0]  pattern_o;
    logic          shift_en_o, capture_o, done_o, pass_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] gstep(input logic [7:0] x);
        return {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
    endfunction

    function automatic logic [7:0] cut(input logic [7:0] p);
        return (p & {p[6:0], 1'b0}) ^ {p[3:0], p[7:4]} ^ 8'h35;
    endfunction

    function automatic logic [7:0] run_sig(input logic md, input logic [7:0] sd, input int lim);
        logic [7:0] p, s;
        p = md ? ((sd == 0) ? 8'h01 : sd) : 8'h00;
        s = 8'h00;
        for (int k = 0; k < lim; k++) begin
            s = gstep(s) ^ cut(p);
            p = md ? gstep(p) : p + 8'h01;
        end
        return s;
    endfunction

    assign response_i = cut(pattern_o);

    bist_ctrl u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .seed_i(seed_i), .shift_len_i(shift_len_i), .pat_limit_i(pat_limit_i),
        .exp_sig_i(exp_sig_i), .response_i(response_i), .pattern_o(pattern_o),
        .shift_en_o(shift_en_o), .capture_o(capture_o), .done_o(done_o), .pass_o(pass_o)
    );

    // behavioural reference: phase 0 idle, 1 seed, 2 scan, 3 capture, 4 compact, 5 done
    int         m_ph = 0;
    int         m_scnt = 0;
    int         m_npat = 0;
    logic [7:0] m_pat = 0, m_sig = 0, m_resp = 0;
    logic       c_md = 0;
    logic [7:0] c_sd = 0, c_exp = 0;
    int         c_len = 0, c_lim = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_pat = 0; m_sig = 0; m_resp = 0; m_scnt = 0; m_npat = 0;
            c_md = 0; c_sd = 0; c_exp = 0; c_len = 0; c_lim = 0;
        end else begin
            case (m_ph)
                0, 5: if (start_i) begin
                    c_md = mode_i; c_sd = seed_i; c_len = int'(shift_len_i);
                    c_lim = int'(pat_limit_i); c_exp = exp_sig_i; m_ph = 1;
                end
                1: begin
                    m_pat = c_md ? ((c_sd == 0) ? 8'h01 : c_sd) : 8'h00;
                    m_sig = 0; m_npat = 0; m_scnt = 0;
                    m_ph = (c_lim == 0) ? 5 : 2;
                end
                2: begin
                    m_scnt++;
                    if (m_scnt >= ((c_len == 0) ? 1 : c_len)) m_ph = 3;
                end
                3: begin
                    m_resp = cut(m_pat); m_ph = 4;
                end
                4: begin
                    m_sig = gstep(m_sig) ^ m_resp;
                    m_pat = c_md ? gstep(m_pat) : m_pat + 8'h01;
                    m_npat++; m_scnt = 0;
                    m_ph = (m_npat == c_lim) ? 5 : 2;
                end
                default: m_ph = 0;
            endcase
        end
    end

    task automatic check1(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        check1("R4/R5 pattern", 32'(pattern_o), 32'(m_pat));
        check1("R2 shift_en", 32'(shift_en_o), 32'(m_ph == 2));
        check1("R3 capture", 32'(capture_o), 32'(m_ph == 3));
        check1("R9 done", 32'(done_o), 32'(m_ph == 5));
        check1("R8 pass", 32'(pass_o), 32'((m_ph == 5) && (m_sig == c_exp)));
    end

    // R6 uniqueness tracking
    logic seen [256];
    logic track = 1'b0;
    int   n_seen = 0;
    always @(negedge clk) begin
        if (track && capture_o) begin
            checks++;
            if (seen[pattern_o]) begin
                errors++;
                $display("FAIL R6: actual repeat %0h expected unique", pattern_o);
            end
            seen[pattern_o] = 1'b1;
            n_seen++;
        end
    end

    task automatic start_run(input logic md, input logic [7:0] sd, input int len,
                             input int lim, input logic [7:0] ex);
        logic [7:0] first;
        @(negedge clk);
        mode_i = md; seed_i = sd; shift_len_i = SW'(len);
        pat_limit_i = CW'(lim); exp_sig_i = ex; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mode_i = ~md; seed_i = ~sd; exp_sig_i = ~ex;   // latched values must be used
        @(negedge clk);
        first = md ? ((sd == 0) ? 8'h01 : sd) : 8'h00;
        if (lim != 0) begin
            check1(md && sd == 0 ? "R7 zero seed" : "R1 first pattern", 32'(pattern_o), 32'(first));
            check1("R1 scan starts", 32'(shift_en_o), 32'd1);
        end
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) seen[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check1("R11 reset done", 32'(done_o), 0);
        check1("R11 reset pattern", 32'(pattern_o), 0);
        rst = 1'b0;

        // exhaustive counter, full space (R4)
        start_run(1'b0, 8'h77, 2, 256, run_sig(1'b0, 8'h00, 256));
        wait_done();
        check1("R4 exhaustive pass", 32'(pass_o), 1);

        // LFSR full period (R5, R6)
        track = 1'b1;
        start_run(1'b1, 8'h5A, 1, 255, run_sig(1'b1, 8'h5A, 255));
        wait_done();
        track = 1'b0;
        check1("R6 distinct count", n_seen, 255);
        check1("R6 no zero", 32'(seen[0]), 0);
        check1("R5 lfsr pass", 32'(pass_o), 1);

        // zero seed, wrong expected signature (R7, R9)
        start_run(1'b1, 8'h00, 3, 5, run_sig(1'b1, 8'h00, 5) ^ 8'h01);
        wait_done();
        check1("R9 mismatch fails", 32'(pass_o), 0);
        // R9 done holds while idle
        repeat (8) @(negedge clk);
        check1("R9 done held", 32'(done_o), 1);

        // shift length 0 acts as 1 (R2), correct signature (R8)
        start_run(1'b1, 8'hC3, 0, 3, run_sig(1'b1, 8'hC3, 3));
        wait_done();
        check1("R8 signature pass", 32'(pass_o), 1);

        // limit 0 (R3)
        start_run(1'b0, 8'h00, 2, 0, 8'h00);
        @(negedge clk);
        check1("R3 zero limit done", 32'(done_o), 1);
        check1("R3 zero limit pass", 32'(pass_o), 1);

        // start during run ignored (R10)
        start_run(1'b0, 8'h00, 4, 4, run_sig(1'b0, 8'h00, 4));
        repeat (3) @(negedge clk);
        start_i = 1'b1; mode_i = 1'b1; pat_limit_i = CW'(9);
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check1("R10 run unchanged pass", 32'(pass_o), 1);

        // reset mid-run (R11)
        start_run(1'b1, 8'h11, 3, 20, 8'h00);
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check1("R11 mid-run reset shift", 32'(shift_en_o), 0);
        check1("R11 mid-run reset pattern", 32'(pattern_o), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check1("R11 stays idle", 32'(done_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule